// File: doc/BRIEF.md
# Serial Highway Frame Timing Generator

This block produces the shared timing for a group of up to four serial data highways. A programmable frame of 2 to 128 eight-bit time slots is counted out in the system clock domain. Each data bit spans four reference ticks. The reference ticks come from one of two sources, each a one-cycle strobe in the system clock domain. In PCM mode the source is a PCM bit-clock strobe, divided by a prescaler factor of 1, 2, 4 or 8, with a PCM frame strobe to resynchronise. In external mode the source is an external data-clock strobe, prescaled in the same way, with an external frame strobe.

The total switching capacity is fixed at 128 slots, so a longer frame leaves fewer usable highways. The block reports the usable port count and enables the data outputs of only those highways. Every highway shares the same bit, slot and frame position. In PCM mode the block also drives a data clock, at the data rate or at twice it, and a frame-sync waveform chosen from four shapes. A frame strobe reloads the counters after a programmable number of bit boundaries, and this moves the frame and the sync output together. A standby input turns off every output enable in one step, and the counters keep running.

Top module: `hwy_frame_timer`

## Requirements
- R1: The frame holds S = slots_m1+1 slots (slots_m1 = 0 gives S = 2) of 8 bits each. The position {slot_idx, bit_in_slot} advances by one at each bit boundary and returns to 0 after bit 8*S-1. After reset the position is 0.
- R2: port_cnt equals the smaller of 4 and 128/S (integer division). When standby is low, hwy_oe[i] is high exactly for i < port_cnt.
- R3: cref_en pulses in the same cycle as a selected source strobe, once every 2^presc_sel source strobes, counted from reset or from the last reload.
- R4: A bit boundary happens on every fourth cref_en pulse. bit_in_slot and slot_idx change only there, or at a reload.
- R5: dclk_out is low during the first two reference ticks of each bit when dclk_x2=0. It is high on the odd ticks when dclk_x2=1.
- R6: The fs_out waveform follows fs_mode. Code 0 is high during bit 0 of the frame. Code 1 is high during slot 0. Code 2 is high while the position is below 4*S. Code 3 is low only during the last bit.
- R7: A frame strobe with fs_offset=0 reloads the counters to position 0 at that clock edge. With fs_offset=N>0, the reload falls on the N-th bit boundary after the strobe. A new strobe restarts the count.
- R8: resync_err is 0 after reset. It is set when a reload does not coincide with a natural frame wrap, and then stays set until reset. An aligned strobe leaves it clear.
- R9: While standby is high, hwy_oe, fs_oe and dclk_oe are all low, and the counters keep advancing.
- R10: With clk_src_ext=1 only ext_tick and ext_fp are used, and fs_oe and dclk_oe are low. With clk_src_ext=0 only pcm_tick and pcm_fp are used.
- R11: frame_start is a one-cycle pulse in the cycle after each wrap or reload, and the position is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_src_ext | input | 1 | 1 selects the external clock and frame source |
| pcm_tick | input | 1 | PCM bit-clock strobe |
| pcm_fp | input | 1 | PCM frame strobe |
| ext_tick | input | 1 | External data-clock strobe |
| ext_fp | input | 1 | External frame strobe |
| presc_sel | input | 2 | Prescaler factor is 2^presc_sel |
| slots_m1 | input | 7 | Slots per frame minus one |
| dclk_x2 | input | 1 | Data clock at twice the data rate |
| fs_mode | input | 2 | Frame-sync waveform code |
| fs_offset | input | 10 | Bit boundaries from frame strobe to reload |
| standby | input | 1 | Forces all output enables low |
| cref_en | output | 1 | Reference clock enable |
| bit_in_slot | output | 3 | Bit index within the slot |
| slot_idx | output | 7 | Slot index within the frame |
| frame_start | output | 1 | Pulse after a wrap or reload |
| port_cnt | output | 3 | Usable highway count |
| dclk_out | output | 1 | Generated data clock |
| dclk_oe | output | 1 | Data clock output enable |
| fs_out | output | 1 | Generated frame-sync |
| fs_oe | output | 1 | Frame-sync output enable |
| hwy_oe | output | 4 | Per-highway data output enable |
| resync_err | output | 1 | Sticky misaligned-reload flag |

## Verification
Several rules are checked on every cycle. The frame position may only hold, step by one or return to zero. frame_start appears only at position zero. The error flag never clears. Standby silences every enable. cref_en needs a source strobe, and a zero-offset strobe is followed by frame_start. The data clock changes only after a reference tick or a reload. The exact prescaler phase, the length of the offset delay, the waveform shapes and the point at which a strobe counts as aligned are shown by the bench scenarios against its own frame model.

// File: rtl/hwy_tmg_pkg.sv
package hwy_tmg_pkg;

  typedef enum logic [1:0] {
    FS_BIT_PULSE  = 2'd0,
    FS_SLOT_PULSE = 2'd1,
    FS_HALF_FRAME = 2'd2,
    FS_LAST_LOW   = 2'd3
  } fs_wave_e;

  // Programmed slot count; anything below two is raised to two.
  function automatic int eff_slots(int m1);
    return (m1 < 1) ? 2 : m1 + 1;
  endfunction

  // Highways that fit into the fixed slot capacity, capped by hardware count.
  function automatic int usable_ports(int slots, int cap_slots, int max_ports);
    int q;
    q = cap_slots / slots;
    return (q > max_ports) ? max_ports : q;
  endfunction

  // Frame-sync level at a given bit position of the frame.
  function automatic logic fs_level(fs_wave_e m, int pos, int slots, int spb);
    logic lvl;
    case (m)
      FS_BIT_PULSE:  lvl = (pos == 0);
      FS_SLOT_PULSE: lvl = (pos < spb);
      FS_HALF_FRAME: lvl = (pos < (slots * spb) / 2);
      default:       lvl = (pos != slots * spb - 1);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/hwy_tmg_presc.sv
module hwy_tmg_presc #(
  parameter int PS_W = 2,
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_tick,
  input  logic [PS_W-1:0] presc_sel,
  input  logic            resync,
  output logic            cref_en,
  output logic            bit_tick,
  output logic [PH_W-1:0] ph
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   fac;

  assign fac      = (CNT_W+1)'(1) << presc_sel;
  assign cref_en  = src_tick && ({1'b0, cnt} >= (fac - (CNT_W+1)'(1)));
  assign bit_tick = cref_en && (ph == {PH_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= '0;
    end else if (resync) begin
      cnt <= '0;
      ph  <= '0;
    end else begin
      if (src_tick) cnt <= cref_en ? '0 : cnt + CNT_W'(1);
      if (cref_en)  ph  <= ph + PH_W'(1);
    end
  end
endmodule

// File: rtl/hwy_tmg_frame.sv
module hwy_tmg_frame #(
  parameter int FBIT_W = 10,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fp,
  input  logic [OFS_W-1:0]  offset,
  input  logic [FBIT_W-1:0] last_bit,
  output logic              resync,
  output logic              wrap,
  output logic [FBIT_W-1:0] bit_cnt,
  output logic              frame_start,
  output logic              resync_err
);
  logic             pend;
  logic [OFS_W-1:0] oc;

  // A fresh strobe takes priority over a countdown already in flight.
  assign resync = fp ? (offset == '0) : (pend && bit_tick && oc == OFS_W'(1));
  assign wrap   = bit_tick && (bit_cnt >= last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      frame_start <= 1'b0;
      resync_err  <= 1'b0;
      pend        <= 1'b0;
      oc          <= '0;
    end else begin
      if (resync || wrap) bit_cnt <= '0;
      else if (bit_tick)  bit_cnt <= bit_cnt + FBIT_W'(1);
      frame_start <= resync || wrap;
      if (resync && !wrap) resync_err <= 1'b1;
      if (fp) begin
        pend <= (offset != '0);
        oc   <= offset;
      end else if (pend && bit_tick) begin
        oc <= oc - OFS_W'(1);
        if (oc == OFS_W'(1)) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hwy_tmg_outs.sv
module hwy_tmg_outs
  import hwy_tmg_pkg::*;
#(
  parameter int NUM_HWY   = 4,
  parameter int PORT_W    = 3,
  parameter int FBIT_W    = 10,
  parameter int SLOT_W    = 7,
  parameter int SLOT_BITS = 8,
  parameter int PH_W      = 2
) (
  input  logic              standby,
  input  logic              ext_mode,
  input  logic              dclk_x2,
  input  logic [PH_W-1:0]   ph,
  input  logic [1:0]        fs_mode,
  input  logic [FBIT_W-1:0] bit_cnt,
  input  logic [SLOT_W:0]   slots,
  input  logic [PORT_W-1:0] port_cnt,
  output logic              dclk_out,
  output logic              dclk_oe,
  output logic              fs_out,
  output logic              fs_oe,
  output logic [NUM_HWY-1:0] hwy_oe
);
  logic gen_oe;

  assign gen_oe   = !standby && !ext_mode;
  assign dclk_oe  = gen_oe;
  assign fs_oe    = gen_oe;
  assign dclk_out = dclk_x2 ? ph[PH_W-2] : ph[PH_W-1];
  assign fs_out   = fs_level(fs_wave_e'(fs_mode), int'(bit_cnt), int'(slots), SLOT_BITS);

  for (genvar i = 0; i < NUM_HWY; i++) begin : g_oe
    assign hwy_oe[i] = !standby && (port_cnt > PORT_W'(i));
  end
endmodule

// File: rtl/hwy_frame_timer.sv
module hwy_frame_timer
  import hwy_tmg_pkg::*;
#(
  parameter int NUM_HWY   = 4,
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_BITS = 8,
  parameter int PS_W      = 2,
  parameter int OFS_W     = 10,
  parameter int PH_W      = 2,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int PORT_W   = $clog2(NUM_HWY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_src_ext,
  input  logic               pcm_tick,
  input  logic               pcm_fp,
  input  logic               ext_tick,
  input  logic               ext_fp,
  input  logic [PS_W-1:0]    presc_sel,
  input  logic [SLOT_W-1:0]  slots_m1,
  input  logic               dclk_x2,
  input  logic [1:0]         fs_mode,
  input  logic [OFS_W-1:0]   fs_offset,
  input  logic               standby,
  output logic               cref_en,
  output logic [BIT_W-1:0]   bit_in_slot,
  output logic [SLOT_W-1:0]  slot_idx,
  output logic               frame_start,
  output logic [PORT_W-1:0]  port_cnt,
  output logic               dclk_out,
  output logic               dclk_oe,
  output logic               fs_out,
  output logic               fs_oe,
  output logic [NUM_HWY-1:0] hwy_oe,
  output logic               resync_err
);
  localparam int FBIT_W = SLOT_W + BIT_W;

  logic              src_tick, fp_sel, bit_tick, resync, wrap;
  logic [PH_W-1:0]   ph;
  logic [FBIT_W-1:0] bit_cnt, last_bit;
  logic [SLOT_W:0]   slots_eff;

  assign src_tick  = clk_src_ext ? ext_tick : pcm_tick;
  assign fp_sel    = clk_src_ext ? ext_fp   : pcm_fp;
  assign slots_eff = (SLOT_W+1)'(eff_slots(int'(slots_m1)));
  assign last_bit  = FBIT_W'(int'(slots_eff) * SLOT_BITS - 1);
  assign port_cnt  = PORT_W'(usable_ports(int'(slots_eff), MAX_SLOTS, NUM_HWY));

  assign bit_in_slot = bit_cnt[BIT_W-1:0];
  assign slot_idx    = bit_cnt[FBIT_W-1:BIT_W];

  hwy_tmg_presc #(.PS_W(PS_W), .PH_W(PH_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .presc_sel(presc_sel),
    .resync   (resync),
    .cref_en  (cref_en),
    .bit_tick (bit_tick),
    .ph       (ph)
  );

  hwy_tmg_frame #(.FBIT_W(FBIT_W), .OFS_W(OFS_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .fp         (fp_sel),
    .offset     (fs_offset),
    .last_bit   (last_bit),
    .resync     (resync),
    .wrap       (wrap),
    .bit_cnt    (bit_cnt),
    .frame_start(frame_start),
    .resync_err (resync_err)
  );

  hwy_tmg_outs #(
    .NUM_HWY(NUM_HWY), .PORT_W(PORT_W), .FBIT_W(FBIT_W),
    .SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .PH_W(PH_W)
  ) u_outs (
    .standby (standby),
    .ext_mode(clk_src_ext),
    .dclk_x2 (dclk_x2),
    .ph      (ph),
    .fs_mode (fs_mode),
    .bit_cnt (bit_cnt),
    .slots   (slots_eff),
    .port_cnt(port_cnt),
    .dclk_out(dclk_out),
    .dclk_oe (dclk_oe),
    .fs_out  (fs_out),
    .fs_oe   (fs_oe),
    .hwy_oe  (hwy_oe)
  );
endmodule

// File: rtl/hwy_frame_timer_chk.sv
module hwy_frame_timer_chk #(
  parameter int NUM_HWY = 4,
  parameter int SLOT_W  = 7,
  parameter int BIT_W   = 3,
  parameter int PORT_W  = 3,
  parameter int OFS_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_src_ext,
  input logic               pcm_tick,
  input logic               pcm_fp,
  input logic               ext_tick,
  input logic               ext_fp,
  input logic               dclk_x2,
  input logic [OFS_W-1:0]   fs_offset,
  input logic               standby,
  input logic               cref_en,
  input logic [BIT_W-1:0]   bit_in_slot,
  input logic [SLOT_W-1:0]  slot_idx,
  input logic               frame_start,
  input logic [PORT_W-1:0]  port_cnt,
  input logic               dclk_out,
  input logic               dclk_oe,
  input logic               fs_oe,
  input logic [NUM_HWY-1:0] hwy_oe,
  input logic               resync_err
);
  localparam int FBIT_W = SLOT_W + BIT_W;

  logic [FBIT_W-1:0] pos;
  logic              sel_tick, sel_fp;

  assign pos      = {slot_idx, bit_in_slot};
  assign sel_tick = clk_src_ext ? ext_tick : pcm_tick;
  assign sel_fp   = clk_src_ext ? ext_fp   : pcm_fp;

  a_r1_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != $past(pos)) |-> (pos == '0 || pos == FBIT_W'($past(pos) + 1'b1)));

  a_r11_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pos == '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    resync_err |=> resync_err);

  a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (hwy_oe == '0 && !fs_oe && !dclk_oe));

  a_r3_cref_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    cref_en |-> sel_tick);

  a_r7_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fp && fs_offset == '0) |=> frame_start);

  a_r5_dclk_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_out != $past(dclk_out) && dclk_x2 == $past(dclk_x2)) |-> ($past(cref_en) || frame_start));

  a_r2_port_range: assert property (@(posedge clk) disable iff (!rst_n)
    (port_cnt >= PORT_W'(1)) && (int'(port_cnt) <= NUM_HWY));

  a_r2_oe_count: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |-> ($countones(hwy_oe) == int'(port_cnt)));
endmodule

bind hwy_frame_timer hwy_frame_timer_chk #(
  .NUM_HWY(NUM_HWY), .SLOT_W(SLOT_W), .BIT_W(BIT_W), .PORT_W(PORT_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/hwy_frame_timer_bench.sv
`timescale 1ns/1ps
module hwy_frame_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       clk_src_ext = 0, pcm_tick = 0, pcm_fp = 0, ext_tick = 0, ext_fp = 0;
  logic [1:0] presc_sel = 0;
  logic [6:0] slots_m1 = 7'd1;
  logic       dclk_x2 = 0;
  logic [1:0] fs_mode = 0;
  logic [9:0] fs_offset = 0;
  logic       standby = 0;
  logic       cref_en, frame_start, dclk_out, dclk_oe, fs_out, fs_oe, resync_err;
  logic [2:0] bit_in_slot, port_cnt;
  logic [6:0] slot_idx;
  logic [3:0] hwy_oe;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // Bench frame model: source strobes since last tick, reference ticks into frame.
  int m_src = 0, m_q = 0, m_oc = 0;
  bit m_pend = 0, m_err = 0, m_fs = 0;

  hwy_frame_timer u_hwy_frame_timer (.*);

  always #2.5 clk = ~clk;

  function automatic int b_slots(int m1);
    return (m1 == 0) ? 2 : m1 + 1;
  endfunction

  function automatic int b_ports(int s);
    if (s <= 32) return 4;
    if (s <= 42) return 3;
    if (s <= 64) return 2;
    return 1;
  endfunction

  function automatic int b_fs(int mode, int pos, int s);
    case (mode)
      0: return (pos == 0) ? 1 : 0;
      1: return (pos <= 7) ? 1 : 0;
      2: return (2 * pos < 8 * s) ? 1 : 0;
      default: return (pos == 8 * s - 1) ? 0 : 1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit src, fp, cref, btick, wrap, rs;
    int last;
    src   = clk_src_ext ? ext_tick : pcm_tick;
    fp    = clk_src_ext ? ext_fp : pcm_fp;
    cref  = src && (m_src >= (1 << presc_sel) - 1);
    btick = cref && (m_q % 4 == 3);
    last  = 8 * b_slots(int'(slots_m1)) - 1;
    wrap  = btick && (m_q / 4 >= last);
    rs    = fp ? (fs_offset == 0) : (m_pend && btick && m_oc == 1);
    m_fs  = rs || wrap;
    if (rs && !wrap) m_err = 1;
    if (rs) begin
      m_src = 0; m_q = 0;
    end else begin
      if (src) m_src = cref ? 0 : m_src + 1;
      if (cref) m_q = wrap ? 0 : m_q + 1;
    end
    if (fp) begin
      m_pend = (fs_offset != 0); m_oc = int'(fs_offset);
    end else if (m_pend && btick) begin
      if (m_oc == 1) m_pend = 0;
      m_oc--;
    end
  endtask

  task automatic compare_outputs();
    int pos, ph, s, ports;
    pos = m_q / 4; ph = m_q % 4;
    s = b_slots(int'(slots_m1));
    ports = b_ports(s);
    check("R4", int'(bit_in_slot), pos % 8, "bit_in_slot");
    check("R1", int'(slot_idx), pos / 8, "slot_idx");
    check("R11", int'(frame_start), int'(m_fs), "frame_start");
    check("R8", int'(resync_err), int'(m_err), "resync_err");
    check("R5", int'(dclk_out), dclk_x2 ? ph % 2 : ph / 2, "dclk_out");
    check("R6", int'(fs_out), b_fs(int'(fs_mode), pos, s), "fs_out");
    check("R2", int'(port_cnt), ports, "port_cnt");
    check("R9", int'(hwy_oe), standby ? 0 : (1 << ports) - 1, "hwy_oe");
    check("R10", int'(fs_oe), int'(!standby && !clk_src_ext), "fs_oe");
    check("R10", int'(dclk_oe), int'(!standby && !clk_src_ext), "dclk_oe");
  endtask

  task automatic cycle();
    bit src;
    #1;
    src = clk_src_ext ? ext_tick : pcm_tick;
    check("R3", int'(cref_en), int'(src && (m_src >= (1 << presc_sel) - 1)), "cref_en");
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_outputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R1 R8 R11: reset state
    check("R1", int'({slot_idx, bit_in_slot}), 0, "reset position");
    check("R8", int'(resync_err), 0, "reset resync_err");
    check("R11", int'(frame_start), 0, "reset frame_start");
    rst_n = 1'b1;

    // R10 R7 R8: external source, strobe aligned with the natural wrap
    clk_src_ext = 1; ext_tick = 1; presc_sel = 0; slots_m1 = 7'd1;
    while (m_q != 63) begin
      pcm_tick = 1'($urandom_range(0, 1)); pcm_fp = 1'($urandom_range(0, 1));
      cycle();
    end
    pcm_fp = 0; ext_fp = 1; cycle(); ext_fp = 0;
    check("R7", int'(frame_start), 1, "aligned zero-offset reload");
    check("R8", int'(resync_err), 0, "aligned strobe leaves error clear");

    // R7: offset of 3 bit boundaries, strobe at phase 0 of a mid-frame bit
    clk_src_ext = 0; pcm_tick = 1; ext_tick = 0; slots_m1 = 7'd31; fs_offset = 10'd3;
    while (!(m_q % 4 == 0 && m_q / 4 >= 4 && m_q / 4 < 200)) cycle();
    pcm_fp = 1; cycle(); pcm_fp = 0;
    t = 1;
    while (!frame_start && t < 40) begin cycle(); t++; end
    check("R7", t, 12, "cycles from strobe to reload with offset 3");
    check("R8", int'(resync_err), 1, "misaligned reload sets error");

    // R9: standby keeps counters moving
    standby = 1; t = int'({slot_idx, bit_in_slot});
    repeat (40) cycle();
    check("R9", int'(int'({slot_idx, bit_in_slot}) != t), 1, "position advanced in standby");
    standby = 0;

    // Random segments over all configurations
    for (int seg = 0; seg < 40; seg++) begin
      int prob, len;
      clk_src_ext = 1'($urandom_range(0, 1));
      presc_sel   = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 7))
        0: slots_m1 = 7'd0;   1: slots_m1 = 7'd1;   2: slots_m1 = 7'd3;
        3: slots_m1 = 7'd31;  4: slots_m1 = 7'd40;  5: slots_m1 = 7'd63;
        6: slots_m1 = 7'd127; default: slots_m1 = 7'($urandom_range(0, 127));
      endcase
      dclk_x2   = 1'($urandom_range(0, 1));
      fs_mode   = 2'($urandom_range(0, 3));
      fs_offset = 10'($urandom_range(0, 6));
      standby   = ($urandom_range(0, 4) == 0);
      prob = $urandom_range(30, 100);
      len  = $urandom_range(300, 1500);
      for (int c = 0; c < len; c++) begin
        pcm_tick = ($urandom_range(0, 99) < prob);
        ext_tick = ($urandom_range(0, 99) < prob);
        pcm_fp   = ($urandom_range(0, 599) == 0);
        ext_fp   = ($urandom_range(0, 599) == 0);
        cycle();
      end
    end
    pcm_fp = 0; ext_fp = 0;
    cycle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule